// File: doc/BRIEF.md
# Burst Line Transfer Bus Master

This block moves one 16-byte line between the chip and an external bus, as either a read or a write. A client offers a request on a valid/ready handshake. The request carries the line address, a read/write flag, the write line and the port size of the addressed slave (32, 16 or 8 bits). The block opens the access with a one-clock start strobe and raises the burst indicator. It then steps through the data beats, and the slave ends each beat with its acknowledge. During a read the block packs the returned bytes into a 128-bit line. During a write it places the line's bytes on the data lanes. A single-cycle done pulse closes the request.

A burst has 4, 8 or 16 beats for a 32-, 16- or 8-bit port. The address stays constant for the whole burst, because the slave advances through the line by itself. A slave that cannot burst answers the first acknowledge with burst-inhibit. The block then finishes the line with separate single-beat cycles. For each of these cycles it computes the address itself, stepping by the port width and wrapping inside the aligned 16-byte block. A burst to a narrow port is atomic: a lock output keeps other masters off the bus until the last beat completes.

Handshake rules: `req_ready` is high only while the block is idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. The client holds its request stable until then. There is no back-pressure inside a transfer: the slave paces the beats with `bus_ta`, and the bench slave acknowledges no earlier than the clock after the start strobe.

Top module: `line_burst_master`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, and `busy`, `done`, `bus_ts`, `bus_burst`, `bus_bdip`, `bus_lock` are all 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. From the next clock `busy`=1 and `req_ready`=0, and they stay that way until the done clock.
- R3: `bus_ts` is high for exactly one clock, at the start of every bus cycle. The first bus cycle starts on the clock after acceptance, and each single cycle starts on the clock after the previous acknowledge. Over a whole request, `bus_ts` pulses 1 time without burst-inhibit, or 4/8/16 times with it (one burst cycle plus 3/7/15 single cycles).
- R4: The first bus cycle is a burst. `bus_burst` is high from its start strobe until the burst ends, and `bus_addr` equals the request address rounded down to the port width, held constant. `req_port_sz` gives the beat count: 0 = 32-bit (4 beats), 1 = 16-bit (8 beats), 2 = 8-bit (16 beats), and 3 behaves as 2.
- R5: `bus_bdip` is high during every burst beat except the last. It is low in every single cycle.
- R6: `bus_bi`=1 with the first acknowledge of a burst ends the burst. The rest of the line is then moved in single cycles with `bus_burst`=0. Beat k (counting from 0 across the whole request) uses the line offset (start + k*width) mod 16, and `bus_addr` = line base + that offset. `bus_bi` is ignored on every other beat.
- R7: Read data arrives on the low lanes of `bus_din`: lane j (bits 8j+7..8j) carries the byte at beat offset + j. The byte at line offset o ends up in `rd_line[8o+7:8o]`.
- R8: During a write, `bus_wr`=1 for every beat. Lane j of `bus_dout` carries `req_wdata[8(o+j)+7:8(o+j)]` for the beat offset o, and lanes at or above the port width are 0.
- R9: `done` pulses for one clock, on the clock after the final acknowledge. In that same clock `busy` has fallen and `rd_line` holds the completed line.
- R10: `bus_lock` is 1 on every beat of a burst to a 16- or 8-bit port. It is 0 for a 32-bit port and during fallback single cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_port_sz | input | 2 | Slave port size: 0 = 32, 1 = 16, 2/3 = 8 bits |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | LINE_W | Line to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_line | output | LINE_W | Packed read line |
| bus_addr | output | ADDR_W | Bus address |
| bus_ts | output | 1 | Transfer start strobe |
| bus_burst | output | 1 | Burst cycle indicator |
| bus_bdip | output | 1 | Another burst beat follows this one |
| bus_wr | output | 1 | Write direction |
| bus_lock | output | 1 | Holds off bus arbitration |
| bus_dout | output | BUS_W | Write data lanes |
| bus_din | input | BUS_W | Read data lanes |
| bus_ta | input | 1 | Slave transfer acknowledge |
| bus_bi | input | 1 | Slave burst inhibit |

## Verification
Each result is due at a fixed cycle:
- The start strobe and `busy` appear one clock after the accepting edge.
- A single cycle's strobe appears one clock after the previous acknowledge edge.
- `done` and the packed line appear on the clock right after the final acknowledge.

The bench slave drives `bus_ta` and `bus_bi` on the falling edge and samples address, qualifiers and write lanes in the same half-cycle. It checks `done` at the falling edge after the last acknowledge. A scoreboard then compares the strobe, beat, BDIP and lock counts and the line contents against values worked out from the offset and port-size rules. Added wait states shift the acknowledges and must leave every count and byte unchanged.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    PS_32 = 2'd0,
    PS_16 = 2'd1,
    PS_8  = 2'd2
  } port_sz_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BEAT  = 2'd2
  } state_e;

  // log2 of the port width in bytes
  function automatic logic [1:0] width_shift(input logic [1:0] ps);
    case (ps)
      PS_32:   width_shift = 2'd2;
      PS_16:   width_shift = 2'd1;
      default: width_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
  import lbm_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic [1:0]       req_port_sz,
  input  logic             bus_ta,
  input  logic             bus_bi,
  output state_e           state,
  output logic [OFF_W-1:0] beat_idx,
  output logic             burst_mode,
  output logic [1:0]       shift,
  output logic             last_beat,
  output logic             beat_ack,
  output logic             done
);
  logic [OFF_W:0] beat_total;

  assign beat_total = (OFF_W+1)'(LINE_BYTES >> shift);
  assign last_beat  = ({1'b0, beat_idx} == beat_total - 1'b1);
  assign beat_ack   = (state == ST_BEAT) && bus_ta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      beat_idx   <= '0;
      burst_mode <= 1'b0;
      shift      <= 2'd0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            state      <= ST_START;
            beat_idx   <= '0;
            burst_mode <= 1'b1;
            shift      <= width_shift(req_port_sz);
          end
        end
        ST_START: state <= ST_BEAT;
        ST_BEAT: begin
          if (bus_ta) begin
            if (last_beat) begin
              state      <= ST_IDLE;
              burst_mode <= 1'b0;
              done       <= 1'b1;
            end else begin
              beat_idx <= beat_idx + 1'b1;
              if (!burst_mode) begin
                state <= ST_START;
              end else if (bus_bi && (beat_idx == '0)) begin
                burst_mode <= 1'b0;
                state      <= ST_START;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbm_addr.sv
module lbm_addr
  import lbm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_port_sz,
  input  logic [OFF_W-1:0]  beat_idx,
  input  logic [1:0]        shift,
  input  logic              burst_mode,
  output logic [OFF_W-1:0]  beat_off,
  output logic [ADDR_W-1:0] bus_addr
);
  logic [ADDR_W-OFF_W-1:0] base_q;
  logic [OFF_W-1:0]        start_q;
  logic [OFF_W-1:0]        align_mask;

  assign align_mask = ~((OFF_W'(1) << width_shift(req_port_sz)) - OFF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
    end else if (req_fire) begin
      base_q  <= req_addr[ADDR_W-1:OFF_W];
      start_q <= req_addr[OFF_W-1:0] & align_mask;
    end
  end

  // wraps naturally inside the line by truncation
  assign beat_off = start_q + (beat_idx << shift);
  assign bus_addr = {base_q, burst_mode ? start_q : beat_off};
endmodule

// File: rtl/lbm_line.sv
module lbm_line #(
  parameter int LINE_BYTES = 16,
  parameter int BUS_BYTES  = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LANE_W = $clog2(BUS_BYTES),
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int BUS_W  = 8 * BUS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic              wr_mode,
  input  logic              beat_ack,
  input  logic [OFF_W-1:0]  beat_off,
  input  logic [1:0]        shift,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dout,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] wline_q;
  logic [OFF_W:0]    lane_cnt;

  assign lane_cnt = (OFF_W+1)'(1) << shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wline_q <= '0;
    else if (req_fire) wline_q <= req_wdata;
  end

  // write lanes: lane j carries line byte beat_off + j
  for (genvar j = 0; j < BUS_BYTES; j++) begin : g_wlane
    logic [OFF_W-1:0] src;
    assign src = beat_off + OFF_W'(j);
    assign bus_dout[8*j +: 8] = ((OFF_W+1)'(j) < lane_cnt) ? wline_q[8*src +: 8] : 8'h00;
  end

  // read packing: each line byte loads from its own lane when the beat covers it
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_rbyte
    logic [OFF_W-1:0] rel;
    logic             hit;
    assign rel = OFF_W'(b) - beat_off;
    assign hit = ({1'b0, rel} < lane_cnt);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_line[8*b +: 8] <= 8'h00;
      else if (beat_ack && !wr_mode && hit) rd_line[8*b +: 8] <= bus_din[8*rel[LANE_W-1:0] +: 8];
    end
  end
endmodule

// File: rtl/line_burst_master.sv
module line_burst_master
  import lbm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int BUS_BYTES  = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int BUS_W  = 8 * BUS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_port_sz,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [LINE_W-1:0] rd_line,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ts,
  output logic              bus_burst,
  output logic              bus_bdip,
  output logic              bus_wr,
  output logic              bus_lock,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic [BUS_W-1:0]  bus_din,
  input  logic              bus_ta,
  input  logic              bus_bi
);
  state_e           state;
  logic [OFF_W-1:0] beat_idx;
  logic [OFF_W-1:0] beat_off;
  logic             burst_mode;
  logic [1:0]       shift;
  logic             last_beat;
  logic             beat_ack;
  logic             req_fire;
  logic             wr_q;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else if (req_fire) wr_q <= req_write;
  end

  assign bus_ts    = (state == ST_START);
  assign bus_burst = busy && burst_mode;
  assign bus_bdip  = busy && burst_mode && !last_beat;
  assign bus_lock  = busy && burst_mode && (shift != 2'd2);
  assign bus_wr    = busy && wr_q;

  lbm_ctrl #(.LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_port_sz(req_port_sz),
    .bus_ta(bus_ta), .bus_bi(bus_bi), .state(state), .beat_idx(beat_idx),
    .burst_mode(burst_mode), .shift(shift), .last_beat(last_beat),
    .beat_ack(beat_ack), .done(done)
  );

  lbm_addr #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_addr(req_addr),
    .req_port_sz(req_port_sz), .beat_idx(beat_idx), .shift(shift),
    .burst_mode(burst_mode), .beat_off(beat_off), .bus_addr(bus_addr)
  );

  lbm_line #(.LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES)) u_line (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_wdata(req_wdata),
    .wr_mode(wr_q), .beat_ack(beat_ack), .beat_off(beat_off), .shift(shift),
    .bus_din(bus_din), .bus_dout(bus_dout), .rd_line(rd_line)
  );
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              bus_ts,
  input logic              bus_burst,
  input logic              bus_bdip,
  input logic              bus_lock,
  input logic [ADDR_W-1:0] bus_addr
);
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> (busy && bus_ts)); // R2
  AST_TS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) bus_ts |=> !bus_ts); // R3
  AST_TS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bus_ts |-> busy); // R3
  AST_BURST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_burst && !bus_ts) |-> $stable(bus_addr)); // R4
  AST_BDIP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) bus_bdip |-> bus_burst); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_LOCK_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) bus_lock |-> bus_burst); // R10
endmodule

bind line_burst_master lbm_checker #(.ADDR_W(ADDR_W)) u_lbm_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .bus_ts(bus_ts), .bus_burst(bus_burst),
  .bus_bdip(bus_bdip), .bus_lock(bus_lock), .bus_addr(bus_addr)
);

// File: tb/sim_line_burst_master.sv
module sim_line_burst_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0004_A5C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         req_valid = 1'b0, req_write = 1'b0;
  logic         req_ready, busy, done;
  logic [1:0]   req_port_sz = 2'd0;
  logic [31:0]  req_addr = '0;
  logic [127:0] req_wdata = '0, rd_line;
  logic [31:0]  bus_addr, bus_dout;
  logic [31:0]  bus_din = 32'hDEAD_BEEF;
  logic         bus_ts, bus_burst, bus_bdip, bus_wr, bus_lock;
  logic         bus_ta = 1'b0, bus_bi = 1'b0;

  line_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port_sz(req_port_sz), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_line(rd_line),
    .bus_addr(bus_addr), .bus_ts(bus_ts), .bus_burst(bus_burst), .bus_bdip(bus_bdip),
    .bus_wr(bus_wr), .bus_lock(bus_lock), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_ta(bus_ta), .bus_bi(bus_bi)
  );

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // current transaction, set by the driver
  logic [7:0]   mem [16];
  int           cur_w = 4, cur_wait = 0;
  int           cur_start = 0;
  bit           cur_bi = 0, cur_wr = 0;
  logic [127:0] cur_wline = '0;

  // slave observations
  int ts_cnt, burst_ts_cnt, bdip_cnt, lock_cnt, beat_cnt, addr_err, lane_err;
  bit done_ok;
  bit open = 0, in_burst = 0, ta_prev = 0, bi_prev = 0, bdip_prev = 0;
  int waits = 0;

  typedef struct {
    bit           wr;
    logic [127:0] line;
    int           n_ts, n_bdip, n_lock, n_beats;
  } item_t;
  item_t sb[$];

  // bus slave: drives acknowledges on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ta_prev) begin
        beat_cnt++;
        if (!in_burst || bi_prev || !bdip_prev) open = 0;
        waits = cur_wait;
        if (beat_cnt == 16 / cur_w) done_ok = (done === 1'b1) && (busy === 1'b0);
      end
      ta_prev = 0; bi_prev = 0;
      bus_ta = 1'b0; bus_bi = 1'b0; bus_din = 32'hDEAD_BEEF;
      if (bus_ts) begin
        ts_cnt++;
        if (bus_burst) burst_ts_cnt++;
        open = 1; in_burst = bus_burst; waits = cur_wait;
      end else if (open) begin
        if (waits > 0) waits--;
        else begin
          int off;
          logic [31:0] ea;
          off = (cur_start + beat_cnt * cur_w) % 16;
          ea = in_burst ? (BASE | 32'(cur_start)) : (BASE | 32'(off));
          if (bus_addr !== ea) addr_err++;
          if (bus_wr !== cur_wr) addr_err++;
          if (bus_bdip) bdip_cnt++;
          if (bus_lock) lock_cnt++;
          for (int j = 0; j < 4; j++) begin
            if (j < cur_w) begin
              if (cur_wr) mem[off + j] = bus_dout[8*j +: 8];
              else bus_din[8*j +: 8] = mem[off + j];
            end else begin
              if (cur_wr && bus_dout[8*j +: 8] !== 8'h00) lane_err++;
              if (!cur_wr) bus_din[8*j +: 8] = 8'hEE;
            end
          end
          bus_ta = 1'b1; ta_prev = 1; bdip_prev = bus_bdip;
          if (in_burst && beat_cnt == 0 && cur_bi) begin
            bus_bi = 1'b1; bi_prev = 1;
          end
        end
      end
    end
  end

  // monitor: scoreboard compare on every done pulse
  always begin
    @(negedge clk); #1;
    if (rst_n && done === 1'b1) begin
      if (sb.size() == 0) check(0, "R9", "unexpected done", 1, 0);
      else begin
        item_t it;
        logic [127:0] got;
        it = sb.pop_front();
        for (int i = 0; i < 16; i++) got[8*i +: 8] = mem[i];
        if (it.wr) check(got === it.line, "R8", "written line", got, it.line);
        else       check(rd_line === it.line, "R7", "read line", rd_line, it.line);
        check(ts_cnt == it.n_ts, "R3", "start strobes", ts_cnt, it.n_ts);
        check(burst_ts_cnt == 1, "R4", "burst starts", burst_ts_cnt, 1);
        check(beat_cnt == it.n_beats, "R4", "beats", beat_cnt, it.n_beats);
        check(bdip_cnt == it.n_bdip, "R5", "bdip beats", bdip_cnt, it.n_bdip);
        check(lock_cnt == it.n_lock, "R10", "lock beats", lock_cnt, it.n_lock);
        check(addr_err == 0, cur_bi ? "R6" : "R4", "address/qualifier errors", addr_err, 0);
        check(lane_err == 0, "R8", "upper lane errors", lane_err, 0);
        check(done_ok, "R9", "done after final ack", done_ok, 1);
      end
    end
  end

  task automatic run(input bit wr, input int off, input int psz, input bit bi, input int wt, input int seed);
    item_t it;
    int w;
    w = (psz == 0) ? 4 : (psz == 1) ? 2 : 1;
    while (busy !== 1'b0) @(negedge clk);
    cur_w = w; cur_wait = wt; cur_bi = bi; cur_wr = wr;
    cur_start = off & ~(w - 1);
    ts_cnt = 0; burst_ts_cnt = 0; bdip_cnt = 0; lock_cnt = 0; beat_cnt = 0;
    addr_err = 0; lane_err = 0; done_ok = 0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(seed * 37 + i * 11 + 5);
      cur_wline[8*i +: 8] = 8'(seed * 53 + i * 29 + 1);
    end
    it.wr = wr;
    for (int i = 0; i < 16; i++) it.line[8*i +: 8] = wr ? cur_wline[8*i +: 8] : mem[i];
    it.n_beats = 16 / w;
    it.n_ts = bi ? 16 / w : 1;
    it.n_bdip = bi ? 1 : 16 / w - 1;
    it.n_lock = (w < 4) ? (bi ? 1 : 16 / w) : 0;
    sb.push_back(it);
    req_valid = 1'b1; req_write = wr; req_port_sz = 2'(psz);
    req_addr = BASE | 32'(off); req_wdata = cur_wline;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1 && req_ready === 1'b0, "R2", "busy after accept", {busy, req_ready}, 2'b10);
    check(bus_ts === 1'b1 && bus_burst === 1'b1, "R3", "strobe one clock after accept", {bus_ts, bus_burst}, 2'b11);
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "R9", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    check(req_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && bus_ts === 1'b0 &&
          bus_burst === 1'b0 && bus_bdip === 1'b0 && bus_lock === 1'b0,
          "R1", "reset outputs", {req_ready, busy, done, bus_ts, bus_burst, bus_bdip, bus_lock}, 7'b1000000);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 0, 0, 0, 0, 1);   // 32-bit read, aligned
    run(0, 8, 0, 0, 1, 2);   // 32-bit read, wraps
    run(0, 7, 1, 0, 0, 3);   // 16-bit read, rounds down to 6
    run(0, 13, 2, 0, 2, 4);  // 8-bit read, wraps
    run(1, 4, 0, 0, 0, 5);   // 32-bit write
    run(1, 9, 2, 0, 1, 6);   // 8-bit write
    run(1, 2, 1, 0, 0, 7);   // 16-bit write
    run(0, 4, 0, 1, 0, 8);   // R6 fallback, 32-bit, 3 singles
    run(0, 10, 1, 1, 1, 9);  // R6 fallback, 16-bit, 7 singles
    run(1, 3, 2, 1, 0, 10);  // R6 fallback write, 8-bit, 15 singles
    run(0, 15, 2, 1, 3, 11); // R6 fallback read, 8-bit, waits
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule